// File: doc/BRIEF.md
# SD Command Response Receiver

This block collects a response token that a card returns on the single-wire command line of an SD bus. It drives the bus clock itself, derived from the system clock by a programmable divider, and samples the command line on every rising edge of that clock. It first hunts for a start bit within a bounded number of clocks. It then checks that the next bit marks a card-to-host transfer. After that it shifts the rest of the token into a byte array, most significant bit first, and gives the card a fixed run of trailing clocks before it reports.

A host sequencer pulses `start` with the expected response length in bytes: 6 for a short response, 17 for a long one, or any length from 1 up to the configured maximum. The block answers with a one-cycle `done` pulse. The `rsp_ok` and `rsp_timeout` flags that come with it stay valid until the next accepted request. The command line is only ever observed; the block never drives it. Checking of the response checksum is left to the consumer of `rsp_data`.

Top module: `sd_rsp_rx`

## Requirements
- R1: While no request is in progress `sd_clk` is low. During a request it starts with a low phase, and each phase lasts exactly DIV_HALF system clock cycles (default 2, so a high phase is 10 ns).
- R2: A `start` pulse is accepted only when the block is idle and `rsp_len` lies in 1..MAX_BYTES. A pulse while busy, or with length 0 or above MAX_BYTES, produces no clock, no `done` and no change to `rsp_data` or the flags.
- R3: The command line is sampled once per rising edge of `sd_clk`. The first low sample is taken as the start bit. A start bit is accepted on any of the first HUNT_LIMIT+2 samples (22 by default), so 21 leading high samples still succeed.
- R4: If HUNT_LIMIT+2 consecutive samples are all high, the request ends after exactly that many rising edges with `rsp_ok`=0 and `rsp_timeout`=1, and no trailing clocks are given.
- R5: The sample after the start bit must be 0. If it is 1, the request ends at once (start-bit position plus 2 rising edges in total) with `rsp_ok`=0 and `rsp_timeout`=0.
- R6: The start bit is bit 0 of the token, and the block clocks in rsp_len×8−2 further bits. Byte k of the token is token bits 8k..8k+7, with the earliest bit as its most significant bit. It appears at `rsp_data[8k+7:8k]`, so bits 7 and 6 of byte 0 always read 0.
- R7: An accepted request clears all of `rsp_data`, so bytes at index rsp_len and above read 0. Outside an accepted request, `rsp_data` holds its value.
- R8: After the last token bit, exactly 8 further rising edges are issued and the command line is ignored during them. A successful request therefore totals (leading high samples) + rsp_len×8 + 8 rising edges and ends with `rsp_ok`=1, `rsp_timeout`=0.
- R9: `done` is high for exactly one system cycle, on the falling clock edge that ends the request, so `sd_clk` is low during `done`. `rsp_ok` and `rsp_timeout` are never both 1, and they hold their value until the next accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request to receive a response |
| rsp_len | input | LEN_W (5) | Expected response length in bytes |
| cmd_in | input | 1 | Level of the SD command line |
| sd_clk | output | 1 | SD bus clock |
| done | output | 1 | One-cycle completion pulse |
| rsp_ok | output | 1 | Last request completed without error |
| rsp_timeout | output | 1 | Last request found no start bit |
| rsp_data | output | MAX_BYTES*8 (136) | Received bytes, byte k at bits 8k+7..8k |

## Verification
The assertions assume that `cmd_in` only moves in the low phase of `sd_clk`, so it is settled at every rising-edge sample. They also assume that `start` is a synchronous pulse and that `rsp_len` only matters in the cycle in which `start` is high. The bench card model moves the command line to its next bit right after each falling edge of `sd_clk`, which leaves it stable for DIV_HALF system cycles before the next sample. Requests are issued at falling system edges, so every input is settled well away from the active edge.

// File: rtl/sd_rsp_pkg.sv
package sd_rsp_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HUNT,
        ST_TBIT,
        ST_DATA,
        ST_TAIL,
        ST_FIN
    } rx_state_e;

    typedef enum logic [1:0] {
        RES_OK,
        RES_TIMEOUT,
        RES_BADTX
    } rx_result_e;

    typedef struct packed {
        logic done;
        logic ok;
        logic timeout;
    } rx_status_t;

    function automatic logic len_in_range(input int unsigned len, input int unsigned max_bytes);
        return (len != 0) && (len <= max_bytes);
    endfunction

endpackage

// File: rtl/sd_rsp_clkgen.sv
module sd_rsp_clkgen #(
    parameter int DIV_HALF = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic sd_clk,
    output logic rise_tick,
    output logic fall_tick
);
    localparam int CNT_W = $clog2(DIV_HALF + 1);

    logic [CNT_W-1:0] cnt;
    logic             clk_q;
    logic             wrap;

    assign wrap      = run && (cnt == CNT_W'(DIV_HALF - 1));
    assign rise_tick = wrap && !clk_q;
    assign fall_tick = wrap && clk_q;
    assign sd_clk    = clk_q;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt   <= '0;
            clk_q <= 1'b0;
        end else if (wrap) begin
            cnt   <= '0;
            clk_q <= ~clk_q;
        end else begin
            cnt   <= cnt + CNT_W'(1);
        end
    end
endmodule

// File: rtl/sd_rsp_fsm.sv
module sd_rsp_fsm
    import sd_rsp_pkg::*;
#(
    parameter int MAX_BYTES  = 17,
    parameter int HUNT_LIMIT = 20,
    parameter int TAIL_CLKS  = 8,
    parameter int LEN_W      = 5,
    parameter int IDX_W      = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [LEN_W-1:0] rsp_len,
    input  logic             cmd_in,
    input  logic             rise_tick,
    input  logic             fall_tick,
    output logic             run,
    output logic             clr,
    output logic             shift_en,
    output logic [IDX_W-1:0] idx,
    output rx_status_t       status
);
    localparam int HUNT_W = $clog2(HUNT_LIMIT + 2) + 1;
    localparam int TAIL_W = $clog2(TAIL_CLKS) + 1;

    rx_state_e        state;
    rx_result_e       res;
    logic [HUNT_W-1:0] hunt_cnt;
    logic [TAIL_W-1:0] tail_cnt;
    logic [LEN_W-1:0]  len_q;
    logic [IDX_W-1:0]  last_idx;
    logic              accept;

    assign accept   = (state == ST_IDLE) && start && len_in_range(32'(rsp_len), MAX_BYTES);
    assign clr      = accept;
    assign run      = (state != ST_IDLE);
    assign shift_en = (state == ST_DATA) && rise_tick;
    assign last_idx = {len_q, 3'b000} - IDX_W'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            res      <= RES_OK;
            hunt_cnt <= '0;
            tail_cnt <= '0;
            len_q    <= '0;
            idx      <= '0;
            status   <= '0;
        end else begin
            status.done <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (accept) begin
                        state          <= ST_HUNT;
                        len_q          <= rsp_len;
                        hunt_cnt       <= '0;
                        status.ok      <= 1'b0;
                        status.timeout <= 1'b0;
                    end
                end
                ST_HUNT: begin
                    if (rise_tick) begin
                        if (!cmd_in) begin
                            state <= ST_TBIT;
                        end else if (hunt_cnt == HUNT_W'(HUNT_LIMIT + 1)) begin
                            res   <= RES_TIMEOUT;
                            state <= ST_FIN;
                        end else begin
                            hunt_cnt <= hunt_cnt + HUNT_W'(1);
                        end
                    end
                end
                ST_TBIT: begin
                    if (rise_tick) begin
                        if (cmd_in) begin
                            res   <= RES_BADTX;
                            state <= ST_FIN;
                        end else begin
                            idx   <= IDX_W'(2);
                            state <= ST_DATA;
                        end
                    end
                end
                ST_DATA: begin
                    if (rise_tick) begin
                        if (idx == last_idx) begin
                            tail_cnt <= '0;
                            state    <= ST_TAIL;
                        end
                        idx <= idx + IDX_W'(1);
                    end
                end
                ST_TAIL: begin
                    if (rise_tick) begin
                        if (tail_cnt == TAIL_W'(TAIL_CLKS - 1)) begin
                            res   <= RES_OK;
                            state <= ST_FIN;
                        end else begin
                            tail_cnt <= tail_cnt + TAIL_W'(1);
                        end
                    end
                end
                ST_FIN: begin
                    if (fall_tick) begin
                        state          <= ST_IDLE;
                        status.done    <= 1'b1;
                        status.ok      <= (res == RES_OK);
                        status.timeout <= (res == RES_TIMEOUT);
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/sd_rsp_pack.sv
module sd_rsp_pack #(
    parameter int MAX_BYTES = 17,
    parameter int IDX_W     = 8
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   clr,
    input  logic                   shift_en,
    input  logic                   bit_in,
    input  logic [IDX_W-1:0]       idx,
    output logic [MAX_BYTES*8-1:0] data
);
    logic [7:0] sh;
    logic [7:0] nxt;
    logic       byte_end;

    assign nxt      = {sh[6:0], bit_in};
    assign byte_end = (idx[2:0] == 3'd7);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            sh <= '0;
        end else if (shift_en) begin
            sh <= byte_end ? 8'h00 : nxt;
        end
    end

    for (genvar k = 0; k < MAX_BYTES; k++) begin : g_byte
        always_ff @(posedge clk) begin
            if (rst || clr) begin
                data[8*k +: 8] <= '0;
            end else if (shift_en && byte_end && (idx[IDX_W-1:3] == (IDX_W-3)'(k))) begin
                data[8*k +: 8] <= nxt;
            end
        end
    end
endmodule

// File: rtl/sd_rsp_rx.sv
module sd_rsp_rx
    import sd_rsp_pkg::*;
#(
    parameter int DIV_HALF   = 2,
    parameter int MAX_BYTES  = 17,
    parameter int HUNT_LIMIT = 20,
    parameter int TAIL_CLKS  = 8,
    parameter int LEN_W      = $clog2(MAX_BYTES + 1)
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   start,
    input  logic [LEN_W-1:0]       rsp_len,
    input  logic                   cmd_in,
    output logic                   sd_clk,
    output logic                   done,
    output logic                   rsp_ok,
    output logic                   rsp_timeout,
    output logic [MAX_BYTES*8-1:0] rsp_data
);
    localparam int IDX_W = LEN_W + 3;

    logic             run;
    logic             rise_tick;
    logic             fall_tick;
    logic             clr;
    logic             shift_en;
    logic [IDX_W-1:0] idx;
    rx_status_t       status;

    sd_rsp_clkgen #(
        .DIV_HALF(DIV_HALF)
    ) u_clkgen (
        .clk      (clk),
        .rst      (rst),
        .run      (run),
        .sd_clk   (sd_clk),
        .rise_tick(rise_tick),
        .fall_tick(fall_tick)
    );

    sd_rsp_fsm #(
        .MAX_BYTES (MAX_BYTES),
        .HUNT_LIMIT(HUNT_LIMIT),
        .TAIL_CLKS (TAIL_CLKS),
        .LEN_W     (LEN_W),
        .IDX_W     (IDX_W)
    ) u_fsm (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .rsp_len  (rsp_len),
        .cmd_in   (cmd_in),
        .rise_tick(rise_tick),
        .fall_tick(fall_tick),
        .run      (run),
        .clr      (clr),
        .shift_en (shift_en),
        .idx      (idx),
        .status   (status)
    );

    sd_rsp_pack #(
        .MAX_BYTES(MAX_BYTES),
        .IDX_W    (IDX_W)
    ) u_pack (
        .clk     (clk),
        .rst     (rst),
        .clr     (clr),
        .shift_en(shift_en),
        .bit_in  (cmd_in),
        .idx     (idx),
        .data    (rsp_data)
    );

    assign done        = status.done;
    assign rsp_ok      = status.ok;
    assign rsp_timeout = status.timeout;
endmodule

// File: rtl/sd_rsp_rx_chk.sv
module sd_rsp_rx_chk #(
    parameter int MAX_BYTES  = 17,
    parameter int HUNT_LIMIT = 20,
    parameter int TAIL_CLKS  = 8,
    parameter int LEN_W      = 5
) (
    input logic                   clk,
    input logic                   rst,
    input logic                   start,
    input logic [LEN_W-1:0]       rsp_len,
    input logic                   sd_clk,
    input logic                   done,
    input logic                   rsp_ok,
    input logic                   rsp_timeout,
    input logic [MAX_BYTES*8-1:0] rsp_data,
    input logic                   run
);
    logic             clk_prev;
    logic [15:0]      rise_cnt;
    logic [LEN_W-1:0] len_seen;
    logic             acc;

    assign acc = start && !run && (rsp_len != '0) && (32'(rsp_len) <= MAX_BYTES);

    always_ff @(posedge clk) begin
        if (rst) begin
            clk_prev <= 1'b0;
            rise_cnt <= '0;
            len_seen <= '0;
        end else begin
            clk_prev <= sd_clk;
            if (acc) begin
                rise_cnt <= '0;
                len_seen <= rsp_len;
            end else if (sd_clk && !clk_prev) begin
                rise_cnt <= rise_cnt + 16'd1;
            end
        end
    end

    AST_IDLE_CLK_LOW: assert property (@(posedge clk) disable iff (rst)
        !run |-> !sd_clk); // R1

    AST_RUN_NEEDS_START: assert property (@(posedge clk) disable iff (rst)
        $rose(run) |-> $past(start)); // R2

    AST_TIMEOUT_EDGES: assert property (@(posedge clk) disable iff (rst)
        (done && rsp_timeout) |-> (rise_cnt == 16'(HUNT_LIMIT + 2))); // R4

    AST_BYTE0_TOP_ZERO: assert property (@(posedge clk) disable iff (rst)
        (done && rsp_ok) |-> (rsp_data[7:6] == 2'b00)); // R6

    AST_DATA_HELD: assert property (@(posedge clk) disable iff (rst)
        (!run && !start) |=> $stable(rsp_data)); // R7

    AST_OK_MIN_EDGES: assert property (@(posedge clk) disable iff (rst)
        (done && rsp_ok) |-> (rise_cnt >= 16'({len_seen, 3'b000}) + 16'(TAIL_CLKS))); // R8

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R9

    AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(rsp_ok && rsp_timeout)); // R9

    AST_DONE_CLK_LOW: assert property (@(posedge clk) disable iff (rst)
        done |-> !sd_clk); // R9
endmodule

bind sd_rsp_rx sd_rsp_rx_chk #(
    .MAX_BYTES (MAX_BYTES),
    .HUNT_LIMIT(HUNT_LIMIT),
    .TAIL_CLKS (TAIL_CLKS),
    .LEN_W     (LEN_W)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .rsp_len    (rsp_len),
    .sd_clk     (sd_clk),
    .done       (done),
    .rsp_ok     (rsp_ok),
    .rsp_timeout(rsp_timeout),
    .rsp_data   (rsp_data),
    .run        (run)
);

// File: tb/sd_rsp_rx_tb.sv
`timescale 1ns/1ps
module sd_rsp_rx_tb;
    localparam int DIV_HALF   = 2;
    localparam int MAX_BYTES  = 17;
    localparam int HUNT_LIMIT = 20;
    localparam int LEN_W      = 5;
    localparam int DW         = MAX_BYTES * 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic [LEN_W-1:0] rsp_len = '0;
    logic          cmd_in;
    logic          sd_clk;
    logic          done;
    logic          rsp_ok;
    logic          rsp_timeout;
    logic [DW-1:0] rsp_data;

    int total = 0;
    int bad   = 0;

    logic       card_bits [0:255];
    int         ptr   = 0;
    int         rises = 0;
    logic [DW-1:0] exp_vec;

    always #2.5 clk = ~clk;

    assign cmd_in = card_bits[ptr];

    always @(posedge sd_clk) rises = rises + 1;
    always @(negedge sd_clk) if (ptr < 255) ptr = ptr + 1;

    sd_rsp_rx #(
        .DIV_HALF  (DIV_HALF),
        .MAX_BYTES (MAX_BYTES),
        .HUNT_LIMIT(HUNT_LIMIT)
    ) u_dut (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .rsp_len    (rsp_len),
        .cmd_in     (cmd_in),
        .sd_clk     (sd_clk),
        .done       (done),
        .rsp_ok     (rsp_ok),
        .rsp_timeout(rsp_timeout),
        .rsp_data   (rsp_data)
    );

    task automatic chk(input bit good, input string req, input logic [255:0] act, input logic [255:0] exp);
        total++;
        if (!good) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    // leading: high samples before the start bit; tbit: value of the second bit
    task automatic load_card(input int leading, input int len, input logic tbit, input int tail_mode);
        logic [7:0] fb;
        exp_vec = '0;
        for (int i = 0; i < 256; i++) card_bits[i] = (tail_mode == 0) ? 1'b0 : logic'(i % 2);
        for (int i = 0; i < leading && i < 256; i++) card_bits[i] = 1'b1;
        for (int k = 0; k < len; k++) begin
            fb = 8'($urandom);
            if (k == 0) begin
                fb[7] = 1'b0;
                fb[6] = tbit;
            end
            if (k == 0) exp_vec[7:0] = {2'b00, fb[5:0]};
            else        exp_vec[8*k +: 8] = fb;
            for (int j = 0; j < 8; j++)
                if (leading + 8*k + j < 256) card_bits[leading + 8*k + j] = fb[7-j];
        end
        ptr   = 0;
        rises = 0;
    endtask

    task automatic pulse_start(input int len);
        @(negedge clk);
        start   = 1'b1;
        rsp_len = LEN_W'(len);
        @(negedge clk);
        start   = 1'b0;
    endtask

    task automatic wait_done(output bit seen);
        seen = 1'b0;
        for (int c = 0; c < 20000 && !seen; c++) begin
            @(negedge clk);
            if (done) seen = 1'b1;
        end
    endtask

    task automatic check_finish(input string req, input bit exp_ok, input bit exp_to, input int exp_rises);
        bit seen;
        wait_done(seen);
        chk(seen, {req, " done seen"}, 256'(seen), 256'(1));
        chk(!sd_clk, "R9 clk low at done", 256'(sd_clk), 256'(0));
        chk(rsp_ok == exp_ok, {req, " ok flag"}, 256'(rsp_ok), 256'(exp_ok));
        chk(rsp_timeout == exp_to, {req, " timeout flag"}, 256'(rsp_timeout), 256'(exp_to));
        chk(rises == exp_rises, {req, " rising edges"}, 256'(rises), 256'(exp_rises));
        @(negedge clk);
        chk(!done, "R9 done one cycle", 256'(done), 256'(0));
    endtask

    task automatic t_reset;
        chk(!sd_clk && !done, "R1 reset idle clk/done", 256'({sd_clk, done}), 256'(0));
        chk(!rsp_ok && !rsp_timeout, "R9 reset flags", 256'({rsp_ok, rsp_timeout}), 256'(0));
        chk(rsp_data == '0, "R7 reset data", 256'(rsp_data), 256'(0));
    endtask

    task automatic t_short_ok;
        load_card(3, 6, 1'b0, 1);
        pulse_start(6);
        check_finish("R8 short", 1'b1, 1'b0, 3 + 48 + 8);
        chk(rsp_data == exp_vec, "R6 short bytes", 256'(rsp_data), 256'(exp_vec));
        repeat (10) @(negedge clk);
        chk(rsp_ok && !rsp_timeout, "R9 flags held", 256'({rsp_ok, rsp_timeout}), 256'(2));
    endtask

    task automatic t_long_ok;
        realtime t0, t1;
        load_card(0, 17, 1'b0, 0);
        pulse_start(17);
        @(posedge sd_clk); t0 = $realtime;
        @(negedge sd_clk); t1 = $realtime;
        chk((t1 - t0) == DIV_HALF * 5.0, "R1 high phase", 256'(int'(t1 - t0)), 256'(DIV_HALF * 5));
        check_finish("R8 long", 1'b1, 1'b0, 0 + 136 + 8);
        chk(rsp_data == exp_vec, "R6 long bytes", 256'(rsp_data), 256'(exp_vec));
    endtask

    task automatic t_hunt_edge;
        load_card(HUNT_LIMIT + 1, 6, 1'b0, 1);
        pulse_start(6);
        check_finish("R3 late start bit", 1'b1, 1'b0, HUNT_LIMIT + 1 + 48 + 8);
        chk(rsp_data == exp_vec, "R3 late start bytes", 256'(rsp_data), 256'(exp_vec));
        chk(rsp_data[DW-1:48] == '0, "R7 unused bytes zero", 256'(rsp_data[DW-1:48]), 256'(0));
    endtask

    task automatic t_timeout;
        load_card(200, 6, 1'b0, 1);
        pulse_start(6);
        check_finish("R4 timeout", 1'b0, 1'b1, HUNT_LIMIT + 2);
        chk(rsp_data == '0, "R7 cleared on accept", 256'(rsp_data), 256'(0));
    endtask

    task automatic t_badtx;
        load_card(5, 6, 1'b1, 1);
        pulse_start(6);
        check_finish("R5 transmission bit", 1'b0, 1'b0, 5 + 2);
    endtask

    task automatic t_busy_start;
        bit seen;
        logic [DW-1:0] keep;
        load_card(2, 6, 1'b0, 1);
        pulse_start(6);
        repeat (40) @(negedge clk);
        pulse_start(17);
        check_finish("R2 start while busy", 1'b1, 1'b0, 2 + 48 + 8);
        chk(rsp_data == exp_vec, "R2 busy start bytes", 256'(rsp_data), 256'(exp_vec));
        keep = rsp_data;
        rises = 0;
        wait_done(seen);
        chk(!seen && rises == 0, "R2 no second request", 256'({seen, 16'(rises)}), 256'(0));
        chk(rsp_data == keep, "R2 data kept", 256'(rsp_data), 256'(keep));
    endtask

    task automatic t_bad_len;
        logic [DW-1:0] keep;
        logic [1:0] flags;
        bit sawdone;
        keep  = rsp_data;
        flags = {rsp_ok, rsp_timeout};
        rises = 0;
        sawdone = 1'b0;
        pulse_start(0);
        pulse_start(MAX_BYTES + 1);
        for (int c = 0; c < 100; c++) begin
            @(negedge clk);
            if (done) sawdone = 1'b1;
        end
        chk(rises == 0 && !sawdone, "R2 bad length ignored", 256'({sawdone, 16'(rises)}), 256'(0));
        chk(rsp_data == keep, "R7 data held on bad length", 256'(rsp_data), 256'(keep));
        chk({rsp_ok, rsp_timeout} == flags, "R9 flags held on bad length", 256'({rsp_ok, rsp_timeout}), 256'(flags));
    endtask

    initial begin
        #(150000 * 5.0);
        total++;
        bad++;
        $display("FAIL watchdog act=hung exp=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < 256; i++) card_bits[i] = 1'b1;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_short_ok();
        t_long_ok();
        t_hunt_edge();
        t_timeout();
        t_badtx();
        t_short_ok();
        t_busy_start();
        t_bad_len();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule